// File: doc/BRIEF.md
# Interrupt Control and Flag Unit

This block holds the single byte-wide interrupt control register of a small microcontroller core and the logic that turns raw events into one interrupt request. It watches three event sources of its own: a one-cycle timer wrap pulse, an external interrupt pin, and six general-purpose port pins whose changes count only where a per-pin change mask allows. It also accepts one aggregated peripheral request line, whose flags live elsewhere.

The three event flags latch whenever their event happens, whatever the enable bits say. They stay set until software writes a zero to them. The request to the core is gated first by a per-source enable and then by a global enable. The peripheral line is gated by its own group enable. The register can be read and written at two bus addresses that share one storage. When the core takes an interrupt it pulses an acknowledge, and the hardware then drops the global enable.

Top module: `irq_ctrl_unit`

## Requirements
- R1: After reset all eight register bits read 0 and `irq_out` is 0. The bit layout, MSB to LSB, is: 7 global enable, 6 peripheral enable, 5 timer enable, 4 external-pin enable, 3 port-change enable, 2 timer flag, 1 external-pin flag, 0 port-change flag.
- R2: A write at address 0x0B or 0x8B loads all eight bits. A read at either address returns the same stored value. Any other address reads 0, and a write to it leaves the register unchanged.
- R3: A high `tmr_wrap` in a cycle sets bit 2 at that clock edge, whatever the enable bits hold.
- R4: `ext_pin` passes through two synchronizer flops. With the default rising-edge setting, a 0-to-1 change sets bit 1 on the third clock edge after the pin changes, and a 1-to-0 change sets nothing.
- R5: A change on any port pin whose `chg_mask` bit is 1 sets bit 0. Changes on pins whose mask bit is 0 are ignored.
- R6: Flags are sticky: only a register write with a 0 in a flag position clears that flag. When a set event and such a write fall in the same cycle, the flag ends up set.
- R7: `irq_out` = bit7 AND ((bit5 & bit2) | (bit4 & bit1) | (bit3 & bit0) | (bit6 & `periph_req`)).
- R8: With bit 7 at 0, `irq_out` stays 0 even when flags are set. With bit 6 at 0, `periph_req` alone cannot raise `irq_out`.
- R9: A high `irq_ack` clears bit 7 at that edge and leaves the other bits alone. It wins over a write of 1 to bit 7 in the same cycle.
- R10: No external-pin or port-change event is detected in the first three cycles after reset, while the synchronizer and compare stages fill. Pins held high through reset therefore set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from address) |
| tmr_wrap | input | 1 | Timer rolled over from maximum to zero this cycle |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| port_pins | input | 6 | Asynchronous general-purpose input pins |
| chg_mask | input | 6 | Per-pin change-detect enable |
| periph_req | input | 1 | Aggregated peripheral interrupt request |
| irq_ack | input | 1 | Core has taken the interrupt |
| irq_out | output | 1 | Interrupt request to the core |

## Verification
The bench holds the pins high through reset. A design without a priming window would then see a false change and latch flags at once. It checks the external-pin latency edge by edge: one synchronizer stage too few or too many moves the flag a cycle early or late. It also drives a falling edge, which a both-edge detector would wrongly latch.

Other tests put a flag-clearing write in the same cycle as a timer wrap, where a write-wins design loses the event. An acknowledge is paired with a write that sets the global enable, where the wrong priority leaves requests open. Finally, the bench toggles an unmasked pin, reads through the mirror address, and writes to a nearby address. These catch a missing mask, a single decoded address, and a loose decode.

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_A = 8'h0B,
  parameter logic [ADDR_W-1:0] ADDR_B = 8'h8B,
  parameter int PORT_W = 6,
  parameter int SYNC_STAGES = 2,
  parameter bit EXT_RISE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              tmr_wrap,
  input  logic              ext_pin,
  input  logic [PORT_W-1:0] port_pins,
  input  logic [PORT_W-1:0] chg_mask,
  input  logic              periph_req,
  input  logic              irq_ack,
  output logic              irq_out
);
  localparam int B_GIE  = 7;
  localparam int B_PEIE = 6;
  localparam int B_TEN  = 5;
  localparam int B_XEN  = 4;
  localparam int B_CEN  = 3;
  localparam int B_TFL  = 2;
  localparam int B_XFL  = 1;
  localparam int B_CFL  = 0;
  localparam int PRIME  = SYNC_STAGES + 1;
  localparam int CNT_W  = $clog2(PRIME + 1);

  logic [7:0] ctl_q, ctl_d;
  logic [SYNC_STAGES-1:0] ext_sync;
  logic ext_prev;
  logic [SYNC_STAGES-1:0][PORT_W-1:0] port_sync;
  logic [PORT_W-1:0] port_prev;
  logic [CNT_W-1:0] prime_cnt;
  logic armed, addr_hit, wr_hit;
  logic ext_now, ext_set, chg_set;
  logic [PORT_W-1:0] port_now;

  assign addr_hit = (bus_addr == ADDR_A) || (bus_addr == ADDR_B);
  assign wr_hit   = bus_wr && addr_hit;
  assign bus_rdata = addr_hit ? ctl_q : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_sync  <= '0;
      ext_prev  <= 1'b0;
      port_sync <= '0;
      port_prev <= '0;
      prime_cnt <= '0;
    end else begin
      ext_sync  <= {ext_sync[SYNC_STAGES-2:0], ext_pin};
      ext_prev  <= ext_now;
      port_sync <= {port_sync[SYNC_STAGES-2:0], port_pins};
      port_prev <= port_now;
      if (!armed) prime_cnt <= prime_cnt + 1'b1;
    end
  end

  assign armed    = (prime_cnt == CNT_W'(PRIME));
  assign ext_now  = ext_sync[SYNC_STAGES-1];
  assign port_now = port_sync[SYNC_STAGES-1];

  generate
    if (EXT_RISE) begin : g_rise
      assign ext_set = armed && ext_now && !ext_prev;
    end else begin : g_fall
      assign ext_set = armed && !ext_now && ext_prev;
    end
  endgenerate

  assign chg_set = armed && |((port_now ^ port_prev) & chg_mask);

  always_comb begin
    ctl_d = ctl_q;
    if (wr_hit) ctl_d = bus_wdata;
    if (irq_ack) ctl_d[B_GIE] = 1'b0;
    if (tmr_wrap) ctl_d[B_TFL] = 1'b1;
    if (ext_set)  ctl_d[B_XFL] = 1'b1;
    if (chg_set)  ctl_d[B_CFL] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= 8'h00;
    else        ctl_q <= ctl_d;
  end

  assign irq_out = ctl_q[B_GIE] &
                   ((ctl_q[B_TEN] & ctl_q[B_TFL]) |
                    (ctl_q[B_XEN] & ctl_q[B_XFL]) |
                    (ctl_q[B_CEN] & ctl_q[B_CFL]) |
                    (ctl_q[B_PEIE] & periph_req));
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_A = 8'h0B,
  parameter logic [ADDR_W-1:0] ADDR_B = 8'h8B
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              tmr_wrap,
  input logic              irq_ack,
  input logic              irq_out,
  input logic [7:0]        ctl
);
  logic hit;
  assign hit = (bus_addr == ADDR_A) || (bus_addr == ADDR_B);

  p_miss_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> bus_rdata == 8'h00);
  p_tmr_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wrap |=> ctl[2]);
  p_tflag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl[2]) |-> $past(bus_wr && hit && !bus_wdata[2]));
  p_xflag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl[1]) |-> $past(bus_wr && hit && !bus_wdata[1]));
  p_cflag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl[0]) |-> $past(bus_wr && hit && !bus_wdata[0]));
  p_gie_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[7] |-> !irq_out);
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !ctl[7]);
endmodule

bind irq_ctrl_unit irq_ctrl_checker #(.ADDR_W(ADDR_W), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_wrap(tmr_wrap),
  .irq_ack(irq_ack), .irq_out(irq_out), .ctl(ctl_q)
);

// File: tb/test_irq_ctrl_unit.sv
`timescale 1ns/1ps
module test_irq_ctrl_unit;
  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 8'h0B, bus_wdata = 0, bus_rdata;
  logic bus_wr = 0, tmr_wrap = 0, ext_pin = 0, periph_req = 0, irq_ack = 0, irq_out;
  logic [5:0] port_pins = 0, chg_mask = 0;
  int total = 0, failed = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_ctrl_unit i_irq_ctrl_unit (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_wrap(tmr_wrap),
    .ext_pin(ext_pin), .port_pins(port_pins), .chg_mask(chg_mask),
    .periph_req(periph_req), .irq_ack(irq_ack), .irq_out(irq_out)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wr = 1; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_addr = 8'h0B;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
    bus_addr = 8'h0B;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    ext_pin = 1; port_pins = 6'h3F; chg_mask = 6'h3F;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (8) @(negedge clk);
    rd(8'h0B, v); chk("R1 reset value / R10 no false edge", v, 8'h00);
    chk("R1 irq_out at reset", {7'b0, irq_out}, 8'h00);
    chg_mask = 0; ext_pin = 0; port_pins = 0;
    repeat (5) @(negedge clk);
    rd(8'h0B, v); chk("R4 falling edge ignored", v, 8'h00);
  endtask

  task automatic t_rw;
    logic [7:0] v;
    wr(8'h0B, 8'hA5); rd(8'h8B, v); chk("R2 write A read B", v, 8'hA5);
    wr(8'h8B, 8'h5A); rd(8'h0B, v); chk("R2 write B read A", v, 8'h5A);
    wr(8'h0C, 8'hFF); rd(8'h0B, v); chk("R2 other address write ignored", v, 8'h5A);
    rd(8'h0C, v); chk("R2 other address reads zero", v, 8'h00);
    wr(8'h0B, 8'h00);
  endtask

  task automatic t_tmr;
    logic [7:0] v;
    @(negedge clk); tmr_wrap = 1;
    @(negedge clk); tmr_wrap = 0; #1;
    chk("R3 timer flag with enables off", bus_rdata, 8'h04);
    repeat (5) @(negedge clk);
    rd(8'h0B, v); chk("R6 flag stays set", v, 8'h04);
    @(negedge clk); tmr_wrap = 1; bus_wr = 1; bus_wdata = 8'h00;
    @(negedge clk); tmr_wrap = 0; bus_wr = 0; #1;
    chk("R6 set wins over clearing write", bus_rdata, 8'h04);
    wr(8'h0B, 8'h00); rd(8'h0B, v); chk("R6 write 0 clears", v, 8'h00);
  endtask

  task automatic t_ext;
    @(negedge clk); ext_pin = 1;
    @(negedge clk); @(negedge clk); #1;
    chk("R4 not yet after two edges", bus_rdata, 8'h00);
    @(negedge clk); #1;
    chk("R4 rising edge sets on third edge", bus_rdata, 8'h02);
    wr(8'h0B, 8'h00);
  endtask

  task automatic t_chg;
    logic [7:0] v;
    chg_mask = 6'b000001;
    @(negedge clk); port_pins[5] = 1;
    repeat (5) @(negedge clk);
    rd(8'h0B, v); chk("R5 unmasked pin ignored", v, 8'h00);
    @(negedge clk); port_pins[0] = 1;
    repeat (5) @(negedge clk);
    rd(8'h0B, v); chk("R5 masked pin change sets flag", v, 8'h01);
    wr(8'h0B, 8'h00); chg_mask = 0;
  endtask

  task automatic t_irq;
    wr(8'h0B, 8'hA0); #1 chk("R7 no flag no request", {7'b0, irq_out}, 8'h00);
    @(negedge clk); tmr_wrap = 1; @(negedge clk); tmr_wrap = 0; #1;
    chk("R7 timer request", {7'b0, irq_out}, 8'h01);
    wr(8'h0B, 8'h24); #1 chk("R8 global enable off blocks", {7'b0, irq_out}, 8'h00);
    periph_req = 1;
    wr(8'h0B, 8'h80); #1 chk("R8 peripheral enable off blocks", {7'b0, irq_out}, 8'h00);
    wr(8'h0B, 8'hC0); #1 chk("R7 peripheral request", {7'b0, irq_out}, 8'h01);
  endtask

  task automatic t_ack;
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0; #1;
    chk("R9 ack clears global enable", bus_rdata, 8'h40);
    chk("R9 request drops", {7'b0, irq_out}, 8'h00);
    @(negedge clk); irq_ack = 1; bus_wr = 1; bus_wdata = 8'hC0;
    @(negedge clk); irq_ack = 0; bus_wr = 0; #1;
    chk("R9 ack beats write", bus_rdata, 8'h40);
    periph_req = 0;
  endtask

  initial begin
    t_reset; t_rw; t_tmr; t_ext; t_chg; t_irq; t_ack;
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule